// File: doc/BRIEF.md
# Programmable Local Bus Strobe Timing Generator

This block sits inside a host-bus bridge and produces the control timing for a simple local peripheral bus. It watches the host bus master's active-low initiator-ready signal. When that signal goes from high to low while the block is idle, an access begins. The reference cycle is the one that starts two clocks after that detection. Every local bus edge is then placed a programmed number of clocks after the reference cycle.

A 32-bit timing register holds eight 4-bit offsets. For each direction it gives the opening and closing of the cycle-active window and the assert and release points of that direction's active-low strobe. The direction is sampled when the access starts. I/O-mapped and memory-mapped accesses use the same timing. The block raises a one-clock completion pulse at the window's closing offset and then returns to idle. Legal offsets are 0 to 10. A larger stored value acts as 10.

The register image and the direction are captured when the access starts. Register writes and further initiator-ready edges during an access therefore do not change the access in progress.

Top module: `lbstrobe_timer`

## Requirements
- R1: After reset `cfg_q` reads 0x21212020. This means read window 0..2, write window 0..2, read strobe 1..2 and write strobe 1..2. After reset `busy` and `cyc_active` are 0, `cyc_done` is 0 and both strobes are high.
- R2: With `cfg_we` high at a clock edge, `cfg_q` shows `cfg_wdata` unchanged after that edge. Reserved values are stored as written. The field positions are: bits [3:0] read window open, [7:4] read window close, [11:8] write window open, [15:12] write window close, [19:16] read strobe assert, [23:20] read strobe release, [27:24] write strobe assert, [31:28] write strobe release.
- R3: An access starts at a clock edge where `irdy_n` is low, `irdy_n` was high at the previous edge, and `busy` is 0. After that edge `busy` is 1 and the access is at clock k=0. Offset n corresponds to clock k=n+2.
- R4: `cyc_active` is high exactly when the offset is at least the open field and below the close field of the sampled direction. Bit 0 of `acc_write` is the direction: 1 means write.
- R5: On a read, `rd_strobe_n` is low exactly when the offset is at least the read assert field and below the read release field. On a read, `wr_strobe_n` stays high.
- R6: On a write, `wr_strobe_n` is low exactly when the offset is at least the write assert field and below the write release field. On a write, `rd_strobe_n` stays high.
- R7: `cyc_done` is high for the single clock at the close offset of the sampled direction. After that clock `busy` is 0 and all outputs are idle.
- R8: Any field value from 11 to 15 behaves as 10.
- R9: If a close field is not above its open field, `cyc_active` stays low for the whole access, and `cyc_done` still comes at the close offset. The same holds for a strobe whose release field is not above its assert field: that strobe stays high.
- R10: While `busy` is 1, new `irdy_n` falling edges are ignored, and register writes do not alter the timing of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write data |
| cfg_q | output | 32 | Timing register contents |
| irdy_n | input | 1 | Host master initiator-ready, active low |
| acc_write | input | 1 | Access direction, 1 = write, sampled at start |
| busy | output | 1 | Access in progress |
| cyc_active | output | 1 | Local cycle window |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| cyc_done | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that `irdy_n` is high while reset is asserted. A start is only recognised on a high-to-low transition, so holding it low out of reset would open an access at the first edge. The bench meets this by keeping `irdy_n` high through reset and between accesses. The bench also raises `irdy_n` again one clock after each start. The only exception is the deliberate mid-access toggle used to test R10. Random field values cover the full 0 to 15 range, so reserved codes and empty windows are reached inside the legal stimulus.

// File: rtl/lbstrobe_pkg.sv
package lbstrobe_pkg;
  localparam int LB_FIELD_W    = 4;
  localparam int LB_NUM_FIELDS = 8;
  localparam int LB_CFG_W      = LB_FIELD_W * LB_NUM_FIELDS;

  // Field slots inside the timing register; direction d (0 rd, 1 wr)
  // uses window slots 2d/2d+1 and strobe slots 4+2d/5+2d.
  localparam int IX_WIN_BASE = 0;
  localparam int IX_STB_BASE = 4;

  localparam logic [LB_CFG_W-1:0] LB_CFG_DEFAULT = 32'h2121_2020;

  function automatic logic [LB_FIELD_W-1:0] lb_field(input logic [LB_CFG_W-1:0] cfg,
                                                     input int idx);
    return cfg[idx*LB_FIELD_W +: LB_FIELD_W];
  endfunction

  function automatic int lb_clamp(input logic [LB_FIELD_W-1:0] v, input int lim);
    return (int'(v) > lim) ? lim : int'(v);
  endfunction

  // True when clock t lies in [lo+ref_dly, hi+ref_dly); empty if hi <= lo.
  function automatic logic lb_in_span(input int t, input int lo, input int hi,
                                      input int ref_dly);
    return (t >= lo + ref_dly) && (t < hi + ref_dly);
  endfunction
endpackage

// File: rtl/lbs_cfg_reg.sv
module lbs_cfg_reg #(
  parameter int CFG_W = 32,
  parameter logic [CFG_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/lbs_seq.sv
module lbs_seq #(
  parameter int CFG_W = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irdy_n,
  input  logic             acc_write,
  input  logic [CFG_W-1:0] cfg_q,
  input  logic             end_hit,
  output logic             start_evt,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic [CFG_W-1:0] snap,
  output logic             dir_q
);
  logic irdy_prev;

  // A start is a high-to-low change of initiator-ready seen while idle.
  assign start_evt = !busy && !irdy_n && irdy_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irdy_prev <= 1'b1;
      busy      <= 1'b0;
      cnt       <= '0;
      snap      <= '0;
      dir_q     <= 1'b0;
    end else begin
      irdy_prev <= irdy_n;
      if (start_evt) begin
        busy  <= 1'b1;
        cnt   <= '0;
        snap  <= cfg_q;
        dir_q <= acc_write;
      end else if (busy) begin
        if (end_hit) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lbs_wave.sv
module lbs_wave
  import lbstrobe_pkg::*;
#(
  parameter int MAX_OFF = 10,
  parameter int REF_DLY = 2,
  parameter int CNT_W   = 4
) (
  input  logic                busy,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [LB_CFG_W-1:0] snap,
  input  logic                dir_q,
  output logic                cyc_active,
  output logic [1:0]          strobe_low,
  output logic                end_hit
);
  logic             win_hit [2];
  logic             stb_hit [2];
  logic [CNT_W-1:0] stop_pt [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_comb begin
      win_hit[d] = lb_in_span(int'(cnt),
                              lb_clamp(lb_field(snap, IX_WIN_BASE + 2*d),     MAX_OFF),
                              lb_clamp(lb_field(snap, IX_WIN_BASE + 2*d + 1), MAX_OFF),
                              REF_DLY);
      stb_hit[d] = lb_in_span(int'(cnt),
                              lb_clamp(lb_field(snap, IX_STB_BASE + 2*d),     MAX_OFF),
                              lb_clamp(lb_field(snap, IX_STB_BASE + 2*d + 1), MAX_OFF),
                              REF_DLY);
      stop_pt[d] = CNT_W'(lb_clamp(lb_field(snap, IX_WIN_BASE + 2*d + 1), MAX_OFF) + REF_DLY);
    end
    assign strobe_low[d] = busy && (dir_q == d[0]) && stb_hit[d];
  end

  assign cyc_active = busy && win_hit[dir_q];
  assign end_hit    = busy && (cnt == stop_pt[dir_q]);
endmodule

// File: rtl/lbstrobe_timer.sv
module lbstrobe_timer
  import lbstrobe_pkg::*;
#(
  parameter int MAX_OFF = 10,
  parameter int REF_DLY = 2,
  parameter logic [LB_CFG_W-1:0] CFG_RESET = LB_CFG_DEFAULT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [LB_CFG_W-1:0] cfg_wdata,
  output logic [LB_CFG_W-1:0] cfg_q,
  input  logic                irdy_n,
  input  logic                acc_write,
  output logic                busy,
  output logic                cyc_active,
  output logic                rd_strobe_n,
  output logic                wr_strobe_n,
  output logic                cyc_done
);
  localparam int CNT_MAX = MAX_OFF + REF_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic                start_evt;
  logic                end_hit;
  logic [CNT_W-1:0]    cnt;
  logic [LB_CFG_W-1:0] snap;
  logic                dir_q;
  logic [1:0]          strobe_low;

  lbs_cfg_reg #(.CFG_W(LB_CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  lbs_seq #(.CFG_W(LB_CFG_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .acc_write(acc_write),
    .cfg_q(cfg_q), .end_hit(end_hit), .start_evt(start_evt), .busy(busy),
    .cnt(cnt), .snap(snap), .dir_q(dir_q)
  );

  lbs_wave #(.MAX_OFF(MAX_OFF), .REF_DLY(REF_DLY), .CNT_W(CNT_W)) u_wave (
    .busy(busy), .cnt(cnt), .snap(snap), .dir_q(dir_q),
    .cyc_active(cyc_active), .strobe_low(strobe_low), .end_hit(end_hit)
  );

  assign rd_strobe_n = ~strobe_low[0];
  assign wr_strobe_n = ~strobe_low[1];
  assign cyc_done    = end_hit;
endmodule

// File: rtl/lbstrobe_checker.sv
module lbstrobe_checker #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cyc_active,
  input logic             rd_strobe_n,
  input logic             wr_strobe_n,
  input logic             cyc_done,
  input logic             start_evt,
  input logic             end_hit,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_q
);
  a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && (cnt == '0));

  a_r10_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !end_hit |=> busy && (cnt == $past(cnt) + CNT_W'(1)));

  a_r4_window_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> busy);

  a_r5_read_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dir_q |-> rd_strobe_n);

  a_r6_write_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dir_q |-> wr_strobe_n);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done && !busy);

  a_r7_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_strobe_n && wr_strobe_n && !cyc_done);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= CNT_MAX);
endmodule

bind lbstrobe_timer lbstrobe_checker #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cyc_active(cyc_active),
  .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .cyc_done(cyc_done),
  .start_evt(start_evt), .end_hit(end_hit), .cnt(cnt), .dir_q(dir_q)
);

// File: tb/lbstrobe_timer_bench.sv
`timescale 1ns/1ps
module lbstrobe_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_q;
  logic        irdy_n = 1'b1;
  logic        acc_write = 1'b0;
  logic        busy, cyc_active, rd_strobe_n, wr_strobe_n, cyc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lbstrobe_timer u_lbstrobe_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .irdy_n(irdy_n), .acc_write(acc_write), .busy(busy),
    .cyc_active(cyc_active), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .cyc_done(cyc_done)
  );

  function automatic int nib(input logic [31:0] v, input int i);
    int raw = int'((v >> (4*i)) & 32'hF);
    return (raw > 10) ? 10 : raw;   // reserved codes act as 10 (R8)
  endfunction

  function automatic bit inside_off(input int k, input int lo, input int hi);
    int o = k - 2;
    return (o >= lo) && (o < hi);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // One access. With interfere set, irdy_n is toggled and the register
  // rewritten to new_cfg during the access (R10).
  task automatic run_access(input logic [31:0] cfg, input bit wr, input bit interfere,
                            input logic [31:0] new_cfg, input string tag);
    int last = 2 + nib(cfg, wr ? 3 : 1);
    @(negedge clk); acc_write = wr; irdy_n = 1'b0;
    for (int k = 0; k <= last + 1; k++) begin
      @(posedge clk); @(negedge clk);
      check(busy == (k <= last), {tag, "/R3 busy"}, busy, k <= last);
      check(cyc_active == ((k <= last) && inside_off(k, nib(cfg, wr ? 2 : 0), nib(cfg, wr ? 3 : 1))),
            {tag, "/R4 active"}, cyc_active, !cyc_active);
      check(rd_strobe_n == !((k <= last) && !wr && inside_off(k, nib(cfg, 4), nib(cfg, 5))),
            {tag, "/R5 rd"}, rd_strobe_n, !rd_strobe_n);
      check(wr_strobe_n == !((k <= last) && wr && inside_off(k, nib(cfg, 6), nib(cfg, 7))),
            {tag, "/R6 wr"}, wr_strobe_n, !wr_strobe_n);
      check(cyc_done == (k == last), {tag, "/R7 done"}, cyc_done, k == last);
      if (k == 0) irdy_n = 1'b1;
      if (interfere && k == 1) begin
        irdy_n = 1'b0; cfg_we = 1'b1; cfg_wdata = new_cfg;
      end
      if (interfere && k == 2) begin
        irdy_n = 1'b1; cfg_we = 1'b0;
      end
    end
    if (interfere) check(cfg_q == new_cfg, {tag, "/R10 cfg"}, cfg_q, new_cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rc;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset image and idle outputs
    check(cfg_q == 32'h2121_2020, "R1 cfg", cfg_q, 32'h2121_2020);
    check(!busy && !cyc_active && !cyc_done && rd_strobe_n && wr_strobe_n,
          "R1 idle", {busy, cyc_active, cyc_done, rd_strobe_n, wr_strobe_n}, 5'b00011);
    // Default timing, both directions
    run_access(32'h2121_2020, 1'b0, 1'b0, '0, "R1dflt");
    run_access(32'h2121_2020, 1'b1, 1'b0, '0, "R1dflt");
    // R2: raw write including reserved codes
    load_cfg(32'hFEDC_BA98);
    check(cfg_q == 32'hFEDC_BA98, "R2 load", cfg_q, 32'hFEDC_BA98);
    // R8: reserved close/release codes act as 10
    load_cfg(32'hEB9C_C9F9);
    run_access(32'hEB9C_C9F9, 1'b0, 1'b0, '0, "R8rd");
    run_access(32'hEB9C_C9F9, 1'b1, 1'b0, '0, "R8wr");
    // R9: empty window and empty strobe
    load_cfg(32'h2736_3535);
    run_access(32'h2736_3535, 1'b0, 1'b0, '0, "R9rd");
    run_access(32'h2736_3535, 1'b1, 1'b0, '0, "R9wr");
    // R10: interference during an access
    load_cfg(32'h5162_7273);
    run_access(32'h5162_7273, 1'b0, 1'b1, 32'h1010_1010, "R10");
    run_access(32'h1010_1010, 1'b1, 1'b0, '0, "R10next");
    // Random accesses
    for (int n = 0; n < 60; n++) begin
      rc = $urandom;
      load_cfg(rc);
      run_access(rc, 1'($urandom), 1'b0, '0, "rand");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule